// File: doc/BRIEF.md
# Synchronous SRAM Cycle Controller

This block sits at the front of a pipelined synchronous SRAM. On each rising clock edge it reads the control inputs and classifies the cycle as one of these: deselect, continue-deselect, read, dummy read, write, wait or sleep. The control inputs are chip select, load/advance, write, byte-lane selects, hold (clock-enable inactive) and output enable. The result appears on a registered operation code. An array-access strobe and the byte lanes to be written come out with the code. A separate block generates the burst addresses and follows the same strobe.

The block also drives the data-bus enable. The bus is driven only while the cycle is a read and output enable is high. Output enable acts on the bus at once, without waiting for a clock edge. During a write the bus stays released whatever the output enable level.

A sleep request may arrive at any time, with no relation to the clock. It passes through a synchronizer. Entry into sleep then takes two cycles and exit takes two cycles. Any burst in flight when entry starts is dropped. During the two exit cycles a chip select is ignored and the cycle counts as a deselect.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: With `adv_i`=0 and `sel_i`=0 the next operation code is DESEL (0). With `adv_i`=1 and no burst open, it is CDESEL (1). In both cases `access_o`=0 and `drive_o`=0.
- R2: With `adv_i`=0, `sel_i`=1, `wr_i`=0 and `hold_i`=0 at an edge, a read burst opens. The code is READ (2) if `oe_i` was 1 at that edge. `access_o`=1 and `access_bw_o`=0. `drive_o` then follows `oe_i` with no clock delay.
- R3: If `oe_i` was 0 at the edge of a read cycle, the code is DUMMY (3). `access_o`=1 and the burst stays open. `drive_o` stays 0 while `oe_i` is 0.
- R4: With `adv_i`=0, `sel_i`=1 and `wr_i`=1, a write burst opens with code WRITE (4). `access_o`=1 and `access_bw_o` takes the `bw_i` sampled at that edge. `drive_o`=0 whatever `oe_i` is.
- R5: With `adv_i`=1 and a burst open, the burst continues. A read burst gives READ or DUMMY by `oe_i`. A write burst gives WRITE, with `bw_i` sampled again on every beat.
- R6: With `hold_i`=1 while awake, the code is WAIT (5) and `access_o`=0. The open burst, `access_bw_o` and the read state that governs `drive_o` are all kept.
- R7: After reset the code is DESEL, `drive_o`=0 even with `oe_i`=1, and `access_o`=0 and `sleep_o`=0.
- R8: `sleep_req_i` is synchronized through two flops. On the edge after the synchronized request rises, a two-cycle entry phase starts. During that phase each cycle is forced to DESEL and any open burst is dropped. `sleep_o` rises after the two cycles.
- R9: On the edge after the synchronized request falls, a two-cycle recovery starts. In those cycles `sel_i` is ignored and each cycle is DESEL with `access_o`=0. Normal decoding resumes after recovery.
- R10: While asleep the code is SLEEP (6), `sleep_o`=1, and `access_o`=0 and `drive_o`=0, including during `hold_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | All chip selects active (1) |
| adv_i | input | 1 | 1 = continue burst, 0 = load new access |
| wr_i | input | 1 | 1 = write access, 0 = read |
| bw_i | input | BW_W | Byte-lane write selects, active high |
| hold_i | input | 1 | 1 = clock-enable inactive, wait state |
| oe_i | input | 1 | Output enable, active high, asynchronous |
| sleep_req_i | input | 1 | Asynchronous sleep request |
| op_o | output | 3 | Registered operation code |
| drive_o | output | 1 | Data-bus drive enable |
| access_o | output | 1 | Array-access strobe |
| access_bw_o | output | BW_W | Byte lanes written with the strobe |
| sleep_o | output | 1 | Sleep state reached |

## Verification
The case where two functions collide is a chip select that arrives while the recovery window is open. A burst that is still open when the synchronized sleep request rises is a second such case. The random run holds the sleep request for random spans while selects, loads and holds keep arriving at a high rate. A directed pass drives selected write loads straight through the recovery window. A cycle-level model in the bench predicts, edge by edge, whether the forced deselect or the normal decode wins. Every output is compared with that prediction in the middle of each cycle.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;
   typedef enum logic [2:0] {
      OP_DESEL  = 3'd0,
      OP_CDESEL = 3'd1,
      OP_READ   = 3'd2,
      OP_DUMMY  = 3'd3,
      OP_WRITE  = 3'd4,
      OP_WAIT   = 3'd5,
      OP_SLEEP  = 3'd6
   } op_e;

   typedef enum logic [1:0] {
      BR_NONE  = 2'd0,
      BR_READ  = 2'd1,
      BR_WRITE = 2'd2
   } burst_e;

   typedef enum logic [1:0] {
      SL_AWAKE = 2'd0,
      SL_ENTER = 2'd1,
      SL_DOWN  = 2'd2,
      SL_EXIT  = 2'd3
   } slp_e;
endpackage

// File: rtl/sram_req_sync.sv
module sram_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sram_req_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sram_sleep_fsm.sv
module sram_sleep_fsm
   import sram_cyc_pkg::*;
#(
   parameter int ENTER_CYC = 2,
   parameter int EXIT_CYC  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_s,
   output logic awake_o,
   output logic enter_o,
   output logic down_o,
   output logic recov_o
);
   localparam int MAXC  = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
   localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

   if (ENTER_CYC < 1 || EXIT_CYC < 1) begin : g_bad_cyc
      $error("sram_sleep_fsm: phase lengths must be at least 1");
   end

   slp_e             st_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SL_AWAKE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            SL_AWAKE: if (req_s) begin
               st_q  <= SL_ENTER;
               cnt_q <= CNT_W'(ENTER_CYC - 1);
            end
            SL_ENTER: if (cnt_q == '0) st_q <= SL_DOWN;
                      else cnt_q <= cnt_q - 1'b1;
            SL_DOWN: if (!req_s) begin
               st_q  <= SL_EXIT;
               cnt_q <= CNT_W'(EXIT_CYC - 1);
            end
            SL_EXIT: if (cnt_q == '0) st_q <= SL_AWAKE;
                     else cnt_q <= cnt_q - 1'b1;
            default: st_q <= SL_AWAKE;
         endcase
      end
   end

   assign awake_o = (st_q == SL_AWAKE);
   assign enter_o = (st_q == SL_ENTER);
   assign down_o  = (st_q == SL_DOWN);
   assign recov_o = (st_q == SL_EXIT);
endmodule

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
   import sram_cyc_pkg::*;
#(
   parameter int BW_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            awake_i,
   input  logic            down_i,
   input  logic            sel_i,
   input  logic            adv_i,
   input  logic            wr_i,
   input  logic [BW_W-1:0] bw_i,
   input  logic            hold_i,
   input  logic            oe_i,
   output op_e             op_o,
   output logic            drive_o,
   output logic            access_o,
   output logic [BW_W-1:0] bw_o
);
   if (BW_W < 1) begin : g_bad_bw
      $error("sram_cycle_decode: BW_W must be at least 1");
   end

   op_e    op_q, op_d;
   burst_e br_q, br_d;
   logic   rd_q, rd_d;
   logic   acc_q, acc_d;
   logic   lane_ld;
   logic   lane_wr;

   always_comb begin
      op_d    = op_q;
      br_d    = br_q;
      rd_d    = rd_q;
      acc_d   = 1'b0;
      lane_ld = 1'b0;
      lane_wr = 1'b0;
      if (!awake_i) begin
         op_d    = down_i ? OP_SLEEP : OP_DESEL;
         br_d    = BR_NONE;
         rd_d    = 1'b0;
         lane_ld = 1'b1;
      end else if (hold_i) begin
         op_d = OP_WAIT;
      end else if (!adv_i) begin
         lane_ld = 1'b1;
         if (sel_i) begin
            acc_d   = 1'b1;
            br_d    = wr_i ? BR_WRITE : BR_READ;
            rd_d    = !wr_i;
            lane_wr = wr_i;
            op_d    = wr_i ? OP_WRITE : (oe_i ? OP_READ : OP_DUMMY);
         end else begin
            br_d = BR_NONE;
            rd_d = 1'b0;
            op_d = OP_DESEL;
         end
      end else begin
         lane_ld = 1'b1;
         unique case (br_q)
            BR_READ: begin
               acc_d = 1'b1;
               rd_d  = 1'b1;
               op_d  = oe_i ? OP_READ : OP_DUMMY;
            end
            BR_WRITE: begin
               acc_d   = 1'b1;
               rd_d    = 1'b0;
               lane_wr = 1'b1;
               op_d    = OP_WRITE;
            end
            default: begin
               rd_d = 1'b0;
               op_d = OP_CDESEL;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= OP_DESEL;
         br_q  <= BR_NONE;
         rd_q  <= 1'b0;
         acc_q <= 1'b0;
      end else begin
         op_q  <= op_d;
         br_q  <= br_d;
         rd_q  <= rd_d;
         acc_q <= acc_d;
      end
   end

   for (genvar g = 0; g < BW_W; g++) begin : g_lane
      logic lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       lane_q <= 1'b0;
         else if (lane_ld) lane_q <= lane_wr & bw_i[g];
      end
      assign bw_o[g] = lane_q;
   end

   assign op_o     = op_q;
   assign access_o = acc_q;
   assign drive_o  = rd_q & oe_i;
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
   import sram_cyc_pkg::*;
#(
   parameter int BW_W        = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ENTER_CYC   = 2,
   parameter int EXIT_CYC    = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sel_i,
   input  logic            adv_i,
   input  logic            wr_i,
   input  logic [BW_W-1:0] bw_i,
   input  logic            hold_i,
   input  logic            oe_i,
   input  logic            sleep_req_i,
   output logic [2:0]      op_o,
   output logic            drive_o,
   output logic            access_o,
   output logic [BW_W-1:0] access_bw_o,
   output logic            sleep_o
);
   logic req_s;
   logic awake_w;
   logic enter_w;
   logic down_w;
   logic recov_w;
   op_e  op_w;

   sram_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sleep_req_i),
      .q_o   (req_s)
   );

   sram_sleep_fsm #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) u_sleep (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_s   (req_s),
      .awake_o (awake_w),
      .enter_o (enter_w),
      .down_o  (down_w),
      .recov_o (recov_w)
   );

   sram_cycle_decode #(.BW_W(BW_W)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .awake_i  (awake_w),
      .down_i   (down_w),
      .sel_i    (sel_i),
      .adv_i    (adv_i),
      .wr_i     (wr_i),
      .bw_i     (bw_i),
      .hold_i   (hold_i),
      .oe_i     (oe_i),
      .op_o     (op_w),
      .drive_o  (drive_o),
      .access_o (access_o),
      .bw_o     (access_bw_o)
   );

   assign op_o    = op_w;
   assign sleep_o = down_w;
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk
   import sram_cyc_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       hold_i,
   input logic [2:0] op_o,
   input logic       drive_o,
   input logic       access_o,
   input logic       sleep_o,
   input logic       awake_w,
   input logic       enter_w,
   input logic       recov_w
);
   AST_ACCESS_IS_ARRAY_OP: assert property (@(posedge clk) disable iff (!rst_n)
      access_o |-> (op_o == OP_READ || op_o == OP_DUMMY || op_o == OP_WRITE)); // R2
   AST_WRITE_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_o == OP_WRITE) |-> !drive_o); // R4
   AST_HOLD_GIVES_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (awake_w && hold_i) |=> (op_o == OP_WAIT && !access_o)); // R6
   AST_ENTRY_FORCES_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      enter_w |=> (op_o == OP_DESEL && !access_o)); // R8
   AST_SLEEP_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_o) |-> $past(enter_w)); // R8
   AST_RECOVERY_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      recov_w |=> (op_o == OP_DESEL && !access_o)); // R9
   AST_ASLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_o |-> (!access_o && !drive_o)); // R10
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hold_i   (hold_i),
   .op_o     (op_o),
   .drive_o  (drive_o),
   .access_o (access_o),
   .sleep_o  (sleep_o),
   .awake_w  (awake_w),
   .enter_w  (enter_w),
   .recov_w  (recov_w)
);

// File: tb/tb_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_sram_cycle_ctrl;
   localparam int BW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel_i = 1'b0, adv_i = 1'b0, wr_i = 1'b0, hold_i = 1'b0;
   logic          oe_i = 1'b1, sleep_req_i = 1'b0;
   logic [BW-1:0] bw_i = '0;
   logic [2:0]    op_o;
   logic          drive_o, access_o, sleep_o;
   logic [BW-1:0] access_bw_o;

   int errors = 0;
   int checks = 0;
   int cyc    = 0;

   // model state
   int            m_s1, m_s2, m_st, m_cnt, m_br;
   logic [2:0]    m_op;
   logic          m_rd, m_acc;
   logic [BW-1:0] m_bw;

   always #5 clk = ~clk;

   sram_cycle_ctrl #(.BW_W(BW)) dut (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .adv_i(adv_i), .wr_i(wr_i),
      .bw_i(bw_i), .hold_i(hold_i), .oe_i(oe_i), .sleep_req_i(sleep_req_i),
      .op_o(op_o), .drive_o(drive_o), .access_o(access_o),
      .access_bw_o(access_bw_o), .sleep_o(sleep_o)
   );

   function automatic string req_of(logic [2:0] op);
      case (op)
         3'd0, 3'd1: return "R1/R8/R9";
         3'd2:       return "R2/R5";
         3'd3:       return "R3/R5";
         3'd4:       return "R4/R5";
         3'd5:       return "R6";
         default:    return "R10";
      endcase
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
      end
   endtask

   task automatic model_reset();
      m_s1 = 0; m_s2 = 0; m_st = 0; m_cnt = 0; m_br = 0;
      m_op = 3'd0; m_rd = 1'b0; m_acc = 1'b0; m_bw = '0;
   endtask

   // one rising edge of the model, inputs as they stand at the edge
   task automatic model_edge();
      m_acc = 1'b0;
      if (m_st != 0) begin
         m_op = (m_st == 2) ? 3'd6 : 3'd0;
         m_br = 0; m_rd = 1'b0; m_bw = '0;
      end else if (hold_i) begin
         m_op = 3'd5;
      end else if (!adv_i) begin
         if (sel_i) begin
            m_acc = 1'b1;
            m_br  = wr_i ? 2 : 1;
            m_rd  = !wr_i;
            m_bw  = wr_i ? bw_i : '0;
            m_op  = wr_i ? 3'd4 : (oe_i ? 3'd2 : 3'd3);
         end else begin
            m_br = 0; m_rd = 1'b0; m_bw = '0; m_op = 3'd0;
         end
      end else begin
         if (m_br == 1) begin
            m_acc = 1'b1; m_rd = 1'b1; m_bw = '0; m_op = oe_i ? 3'd2 : 3'd3;
         end else if (m_br == 2) begin
            m_acc = 1'b1; m_rd = 1'b0; m_bw = bw_i; m_op = 3'd4;
         end else begin
            m_rd = 1'b0; m_bw = '0; m_op = 3'd1;
         end
      end
      case (m_st)
         0: if (m_s2 != 0) begin m_st = 1; m_cnt = 1; end
         1: if (m_cnt == 0) m_st = 2; else m_cnt--;
         2: if (m_s2 == 0) begin m_st = 3; m_cnt = 1; end
         default: if (m_cnt == 0) m_st = 0; else m_cnt--;
      endcase
      m_s2 = m_s1;
      m_s1 = int'(sleep_req_i);
   endtask

   task automatic compare_all();
      string r;
      r = req_of(m_op);
      chk(r, "op", int'(op_o), int'(m_op));
      chk(r, "access", int'(access_o), int'(m_acc));
      chk(r, "bw", int'(access_bw_o), int'(m_bw));
      chk("R2/R3/R4", "drive", int'(drive_o), int'(m_rd & oe_i));
      chk("R8/R10", "sleep", int'(sleep_o), (m_st == 2) ? 1 : 0);
   endtask

   // negedge: compare, then apply new inputs; posedge: advance model
   task automatic step(logic s, logic a, logic w, logic [BW-1:0] b, logic h, logic o);
      sel_i = s; adv_i = a; wr_i = w; bw_i = b; hold_i = h; oe_i = o;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      cyc++;
      compare_all();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int seed_dummy;
      int slp_left;
      seed_dummy = $urandom(32'h5EED_1234);
      model_reset();
      repeat (3) @(negedge clk);
      // R7: reset state with output enable high
      chk("R7", "op", int'(op_o), 0);
      chk("R7", "drive", int'(drive_o), 0);
      chk("R7", "access", int'(access_o), 0);
      chk("R7", "sleep", int'(sleep_o), 0);
      rst_n = 1'b1;

      // directed: R1 deselect and continue-deselect
      step(1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1);
      step(1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1);
      // R2 read then async oe drop, R5 continue
      step(1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1);
      oe_i = 1'b0; #1;
      chk("R2", "drive async off", int'(drive_o), 0);
      step(1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0);   // R3 dummy continue
      step(1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 1'b1);   // R6 hold keeps drive
      // R4 write with oe high, R5 new lanes per beat
      step(1'b1, 1'b0, 1'b1, 4'h5, 1'b0, 1'b1);
      step(1'b1, 1'b1, 1'b1, 4'hA, 1'b0, 1'b1);
      step(1'b1, 1'b1, 1'b1, 4'h3, 1'b1, 1'b1);   // R6 lanes held

      // directed: R8 sleep entry with a write burst open, R9 selects during recovery
      sleep_req_i = 1'b1;
      for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 1'b1);
      chk("R10", "asleep", int'(sleep_o), 1);
      step(1'b1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1);
      sleep_req_i = 1'b0;
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1, 4'hC, 1'b0, 1'b1);
      chk("R9", "resumed write", int'(op_o), 4);

      // random phase
      slp_left = 0;
      for (int i = 0; i < 4000; i++) begin
         if (slp_left == 0) begin
            if ($urandom_range(0, 150) == 0) begin
               sleep_req_i = ~sleep_req_i;
               slp_left = $urandom_range(3, 30);
            end
         end else slp_left--;
         step($urandom_range(0, 9) < 7, $urandom_range(0, 9) < 4,
              $urandom_range(0, 9) < 4, BW'($urandom),
              $urandom_range(0, 9) < 2, $urandom_range(0, 9) < 7);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule